// File: doc/BRIEF.md
# Framed Serial Sample Transmitter

This block sends 16-bit two's-complement sample words as a synchronous serial stream. It makes its own serial clock by dividing the system clock by four. Each frame lasts 32 serial clock cycles: the sample goes out most significant bit first during the first 16 cycles, and zeros fill the other 16. Alongside the data it drives a frame-sync output. The waveform of that output, and the serial clock edge on which data is valid, are both chosen by one format input.

A frame-sync input lets the block lock to an outside timing source. A rising level on that input aborts the frame in progress and starts a new one. If the input holds still, frames repeat on their own. The data line is modelled as a value plus an output-enable, so two instances can share one wire. The enable input's active level is set by a slot-select input, and the zero padding leaves the second half of each frame free for the partner. New samples are taken through a valid/ready handshake once per frame. If no sample is offered, the previous one is sent again.

Top module: `frame_serial_tx`

## Requirements
- R1: The serial clock period is 4 system cycles with a 50 % duty cycle, and each serial cycle begins with system phase 0. With the format input high (square mode) the serial clock is low for phases 0–1 and high for phases 2–3. With format low (pulse mode) it is the inverse.
- R2: A frame is 32 serial cycles, numbered 0 to 31. In cycle k < 16 the data output carries bit 15−k of the latched sample. In cycles 16 to 31 it carries 0.
- R3: The data output changes only at serial-cycle boundaries. It is therefore stable across the mid-cycle serial clock edge, which is falling in pulse mode and rising in square mode.
- R4: In pulse mode (format = 0) frame sync is 1 only during serial cycle 31, the cycle just before the MSB, and 0 elsewhere.
- R5: In square mode (format = 1) frame sync is 0 during serial cycles 0–15 and 1 during cycles 16–31.
- R6: While the frame-sync input does not rise, a new frame starts every 128 system cycles.
- R7: The frame-sync input is sampled on the falling system clock edge. The first falling-edge sample of 1 that follows a sample of 0 restarts the frame: serial cycle 0, phase 0 begins at the second rising edge after that falling edge. A level held high or low, including high through reset, causes no restart.
- R8: Outside reset, the output-enable is 1 exactly when the enable input equals the slot-select input, and 0 otherwise.
- R9: The ready output is 1 only in the system cycle just before a frame start (automatic or restart). The sample offered with valid in that cycle is latched and held unchanged for the whole frame.
- R10: If valid is low at a frame start, the previously latched sample is sent again.
- R11: During reset the output-enable is 0, ready is 0, the data output is 0, and frame sync is at its idle level (0 in pulse mode, 1 in square mode). The block resumes in serial cycle 30, phase 0, with a latched sample of 0, so the first frame starts 8 system cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_i | input | 1 | Format: 0 pulse frame sync / data valid on falling edge, 1 square frame sync / valid on rising edge |
| slot_i | input | 1 | Level at which den_i enables the data output |
| den_i | input | 1 | Data output enable request |
| fsi_i | input | 1 | Frame-sync input, asynchronous |
| s_valid_i | input | 1 | Sample offered |
| s_data_i | input | 16 | Sample word, two's complement |
| s_ready_o | output | 1 | Sample accepted at the next rising edge if valid |
| sclk_o | output | 1 | Serial clock |
| fso_o | output | 1 | Frame-sync output |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output-enable (0 = high impedance) |

## Verification
All outputs are decoded directly from registered state, so each one is due in the same cycle as the rising edge that updates the phase and frame counters. The bench samples them 1 ns after every rising edge and compares them with a cycle-position model that it advances itself. A frame-sync rise driven just after a rising edge is captured at the next falling edge. Ready is then due one rising edge later and serial cycle 0 one edge after that, so the model schedules the restart two steps ahead. Frame-period and word-repeat checks are made on whole shifted words and on the spacing of observed ready pulses. Neither depends on the design's internals.

// File: rtl/fstx_pkg.sv
`timescale 1ns/1ps
// Shared types of the framed serial transmitter.
package fstx_pkg;
    // Frame-sync waveform / valid-edge choice, decoded from the format input.
    typedef enum logic {
        FMT_PULSE  = 1'b0,
        FMT_SQUARE = 1'b1
    } fs_fmt_e;
endpackage

// File: rtl/fstx_clkdiv.sv
`timescale 1ns/1ps
// Serial clock divider.
// Counts system-clock phases 0..DIV-1 within one serial cycle and shapes the
// serial clock so that its mid-cycle edge is rising (square format) or
// falling (pulse format).
// Assumes DIV is even and at least 2. restart_i forces phase 0 at the next edge.
module fstx_clkdiv #(
    parameter  int DIV  = 4,
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic fmt_i,
    output logic last_o,
    output logic sclk_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

    logic [PH_W-1:0] ph_q;
    logic            upper_half;

    // Phase counter: wraps at DIV-1, cleared by a frame restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (restart_i || last_o) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Serial clock shaping: edge sits mid-cycle, polarity chosen by format.
    always_comb begin
        last_o     = (ph_q == PH_LAST);
        upper_half = (ph_q >= PH_HALF);
        sclk_o     = fmt_i ? upper_half : ~upper_half;
    end

    // R1
    ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !last_o) |=> (ph_q == $past(ph_q) + 1'b1));
endmodule

// File: rtl/fstx_fsi_sync.sv
`timescale 1ns/1ps
// Frame-sync input synchronizer and rise detector.
// The first stage captures the asynchronous input on the falling system edge,
// the second on the rising edge. A third rising-edge flop holds the previous
// synchronized level. Every stage resets to 1, so a level already high at
// reset is never taken as a rise. Assumes the half-cycle settling window
// between the first two stages is adequate at the target clock rate.
module fstx_fsi_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic fsi_i,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // First stage: sample the raw input on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
        end else begin
            meta_q <= fsi_i;
        end
    end

    // Second stage and history flop on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rise flag: synchronized level went from 0 to 1.
    always_comb rise_o = sync_q & ~prev_q;

    // R7
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/fstx_framer.sv
`timescale 1ns/1ps
// Frame sequencer.
// Counts serial cycles within a frame, latches one sample per frame through
// a valid/ready handshake, serializes it MSB first with zero padding, and
// decodes the frame-sync output for the selected format.
// Assumes FRAME_LEN > SAMPLE_W so that the pulse cycle lies in the padding.
module fstx_framer
    import fstx_pkg::*;
#(
    parameter  int SAMPLE_W  = 16,
    parameter  int FRAME_LEN = 32,
    localparam int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i,
    input  logic                last_ph_i,
    input  logic                restart_i,
    input  logic                s_valid_i,
    input  logic [SAMPLE_W-1:0] s_data_i,
    output logic                s_ready_o,
    output logic                sdo_o,
    output logic                fso_o
);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(FRAME_LEN - 2);
    localparam logic [CNT_W-1:0] CNT_DATA  = CNT_W'(SAMPLE_W);

    fs_fmt_e             fmt;
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] aligned;
    logic                wrap;
    logic                frame_start;
    logic                in_data;

    // Frame boundary decode: natural wrap or external restart.
    always_comb begin
        fmt         = fs_fmt_e'(fmt_i);
        wrap        = last_ph_i && (cnt_q == CNT_LAST);
        frame_start = wrap || restart_i;
        s_ready_o   = frame_start;
    end

    // Serial-cycle counter within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_RESET;
        end else if (frame_start) begin
            cnt_q <= '0;
        end else if (last_ph_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sample latch: loads only at a frame start with valid, else holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (frame_start && s_valid_i) begin
            word_q <= s_data_i;
        end
    end

    // Serializer and frame-sync decode.
    always_comb begin
        in_data = (cnt_q < CNT_DATA);
        aligned = word_q << cnt_q;
        sdo_o   = in_data ? aligned[SAMPLE_W-1] : 1'b0;
        if (fmt == FMT_SQUARE) begin
            fso_o = ~in_data;
        end else begin
            fso_o = (cnt_q == CNT_LAST);
        end
    end

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(word_q));

    // R6
    auto_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/frame_serial_tx.sv
`timescale 1ns/1ps
// Framed serial sample transmitter, top level.
// Ties the divider, frame-sync synchronizer and frame sequencer together and
// gates the data output-enable by the slot-select polarity. The tri-state
// itself is left to the pad ring: sdo_oe_o = 0 means high impedance.
// Assumes fmt_i and slot_i are static while not in reset.
module frame_serial_tx #(
    parameter int SAMPLE_W  = 16,
    parameter int FRAME_LEN = 32,
    parameter int DIV       = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i,
    input  logic                slot_i,
    input  logic                den_i,
    input  logic                fsi_i,
    input  logic                s_valid_i,
    input  logic [SAMPLE_W-1:0] s_data_i,
    output logic                s_ready_o,
    output logic                sclk_o,
    output logic                fso_o,
    output logic                sdo_o,
    output logic                sdo_oe_o
);
    logic restart;
    logic last_ph;
    logic live_q;

    fstx_fsi_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .fsi_i  (fsi_i),
        .rise_o (restart)
    );

    fstx_clkdiv #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .fmt_i     (fmt_i),
        .last_o    (last_ph),
        .sclk_o    (sclk_o)
    );

    fstx_framer #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_i     (fmt_i),
        .last_ph_i (last_ph),
        .restart_i (restart),
        .s_valid_i (s_valid_i),
        .s_data_i  (s_data_i),
        .s_ready_o (s_ready_o),
        .sdo_o     (sdo_o),
        .fso_o     (fso_o)
    );

    // Output-enable arming: held off throughout reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
        end
    end

    // Drive the shared line only when the enable matches the slot level.
    always_comb sdo_oe_o = live_q && (den_i == slot_i);
endmodule

// File: tb/frame_serial_tx_tb_top.sv
`timescale 1ns/1ps
module frame_serial_tx_tb_top;
    localparam int SW  = 16;
    localparam int FL  = 32;
    localparam int DV  = 4;
    localparam int FRM = FL * DV;

    logic clk = 1'b0;
    logic rst_n, fmt, slot, den, fsi, s_valid;
    logic [SW-1:0] s_data;
    logic s_ready, sclk, fso, sdo, sdo_oe;

    int checks = 0;
    int errors = 0;
    int t, rs_pend, ticks, last_ready, nfr, rdy_cnt;
    logic [SW-1:0] cur_word, rx;
    logic framed, rep_frame;

    always #2.5 clk = ~clk;

    frame_serial_tx #(.SAMPLE_W(SW), .FRAME_LEN(FL), .DIV(DV)) dut_i (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .slot_i(slot), .den_i(den),
        .fsi_i(fsi), .s_valid_i(s_valid), .s_data_i(s_data),
        .s_ready_o(s_ready), .sclk_o(sclk), .fso_o(fso), .sdo_o(sdo),
        .sdo_oe_o(sdo_oe));

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] pat(input int n);
        return 16'h8001 ^ (16'(n) * 16'h3C5B);
    endfunction

    task automatic latch();
        rep_frame = !s_valid;
        if (s_valid) cur_word = s_data;
        rx = '0;
        framed = 1'b1;
    endtask

    task automatic compare();
        cmp("R1 sclk", sclk, fmt ? ((t % DV) >= DV/2) : ((t % DV) < DV/2));
        cmp("R2 R3 sdo", sdo, (t / DV < SW) ? cur_word[SW-1-t/DV] : 1'b0);
        if (fmt) cmp("R5 fsync", fso, (t / DV) >= SW);
        else     cmp("R4 fsync", fso, (t / DV) == FL-1);
        cmp("R9 ready", s_ready, (t == FRM-1) || (rs_pend == 1));
        if ((t % DV) == DV/2 && (t / DV) < SW) rx = {rx[SW-2:0], sdo};
        if (t == SW*DV && framed) begin
            if (rep_frame) cmp("R10 repeat word", rx, cur_word);
            else           cmp("R2 word", rx, cur_word);
        end
        if (s_ready) begin
            rdy_cnt++;
            if (last_ready >= 0) cmp("R6 period", ticks - last_ready, FRM);
            last_ready = ticks;
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
        ticks++;
        if (rs_pend == 1) begin
            t = 0; rs_pend = 0; latch();
        end else begin
            t = (t + 1) % FRM;
            if (t == 0) latch();
            if (rs_pend == 2) rs_pend = 1;
        end
        compare();
    endtask

    task automatic do_reset(input logic f, input logic fs_lvl);
        rst_n = 1'b0; fmt = f; fsi = fs_lvl; s_valid = 1'b0; s_data = '0;
        repeat (3) @(posedge clk);
        #1;
        t = (FL - 2) * DV; rs_pend = 0; cur_word = '0; rx = '0;
        framed = 1'b0; rep_frame = 1'b0; last_ready = -1; rdy_cnt = 0;
        cmp("R11 oe in reset", sdo_oe, 1'b0);
        cmp("R11 fsync idle", fso, f);
        cmp("R11 ready", s_ready, 1'b0);
        cmp("R11 sdo", sdo, 1'b0);
        cmp("R11 sclk", sclk, !f);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; fmt = 1'b0; slot = 1'b0; den = 1'b0; fsi = 1'b0;
        s_valid = 1'b0; s_data = '0; ticks = 0;
        for (int f = 0; f < 2; f++) begin
            do_reset(f[0], 1'b0);
            nfr = 0; s_valid = 1'b1; s_data = pat(0);
            for (int k = 0; k < 6 * FRM; k++) begin
                step();
                if (t == 0) begin
                    nfr++;
                    s_data  = pat(nfr + 7 * f);
                    s_valid = (nfr % 4) != 2;
                end
                // R7: rise mid-frame restarts, later fall has no effect
                if (k == 400) begin fsi = 1'b1; rs_pend = 2; last_ready = -1; end
                if (k == 600) fsi = 1'b0;
            end
        end
        // R8: enable polarity sweep
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < 2; s++) begin
                den = d[0]; slot = s[0];
                step();
                cmp("R8 oe", sdo_oe, d == s);
            end
        end
        // R7: level held high through reset is not a rise
        do_reset(1'b1, 1'b1);
        s_valid = 1'b1; s_data = 16'h7FFF;
        for (int k = 0; k < 300; k++) step();
        cmp("R7 held fsi no restart", rdy_cnt, 3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule